// File: doc/BRIEF.md
# Break-Protected Two-Step Status Flags

This block holds a small bank of peripheral status flags. A hardware event input sets each flag. Software clears a flag in two steps. It first reads the status register while the flag is set, which arms that flag. It then makes any access, read or write, to the data register, and that access clears every armed flag. A set event also disarms its flag, so an event that arrives after the status read needs a fresh status read before it can be cleared.

A debug break input can freeze the clearing. A clear-enable bit in the break control register decides what happens while break is active. With the bit at 0, no register access clears a flag, and armed markers are kept. The second step made after break ends therefore still clears the flag, without a new status read. With the bit at 1, clearing works during break as it does outside it, and a flag cleared that way stays cleared once break ends. Register reads and writes otherwise behave normally in break.

Top module: `brkf_flag_bank`

## Requirements
- R1: After reset every flag is 0, no flag is armed, and the clear-enable bit is 0.
- R2: A read at address 0 (status) returns the flags in data bits [NUM_FLAGS-1:0] and zeros above them. Read data appears one clock after the read strobe. A pulse on set_evt[i] makes flags[i] 1 one clock later.
- R3: Outside break, a status read followed by a read or a write at address 1 (data) clears every flag that read as 1 in that status read. The flags drop one clock after the data access.
- R4: A flag that was 0 at the status read, or that received a set event after it, is not cleared by the next data access.
- R5: While brk_active is 1 and the clear-enable bit is 0, no access clears any flag. The armed markers survive, so the first data access after break ends clears the flags that were armed before or during break.
- R6: While brk_active is 1 and the clear-enable bit is 1, the two-step clear works as in R3, and a cleared flag stays 0 after break ends.
- R7: A set event in the same cycle as a clearing data access wins. The flag stays 1 and is disarmed, so a further data access does not clear it.
- R8: Address 2 (control) holds the clear-enable bit in data bit 0. It is writable and reads back with all other bits 0.
- R9: A data access with no armed flag leaves the flags unchanged. A write to the status address has no effect on the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wr_en | input | 1 | Write strobe, one cycle per access |
| addr | input | ADDR_W | Register address: 0 status, 1 data, 2 control |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Registered read data, valid the cycle after rd_en |
| set_evt | input | NUM_FLAGS | Per-flag hardware set events |
| brk_active | input | 1 | Debug break is in progress |
| flags | output | NUM_FLAGS | Current flag values |

## Verification
The assertions assume that set_evt, brk_active and the bus strobes are stable between rising edges. They also assume that each register access lasts exactly one cycle and that set_evt stays 0 while reset is asserted. The bench drives every input on the falling edge and issues one single-cycle access per call. It holds set_evt at 0 during reset, and it changes brk_active only between accesses, so every window the properties watch starts from a defined state after reset.

// File: rtl/brkf_pkg.sv
// Package: shared register offsets and the decoded bus command type.
// Assumes the address bus is at least two bits wide.
package brkf_pkg;
    parameter int unsigned OFS_STATUS = 0;
    parameter int unsigned OFS_DATA   = 1;
    parameter int unsigned OFS_CTRL   = 2;

    typedef struct packed {
        logic status_rd;  // first clearing step
        logic data_acc;   // second clearing step (read or write)
        logic ctrl_wr;
        logic ctrl_rd;
    } bus_cmd_t;
endpackage

// File: rtl/brkf_regif.sv
// Register decode: turns strobes and address into one-hot style commands.
// Assumes one access per cycle; read and write at once count as one access.
module brkf_regif
    import brkf_pkg::*;
#(
    parameter int unsigned ADDR_W = 2
) (
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    output bus_cmd_t          cmd
);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);
    localparam logic [ADDR_W-1:0] A_DATA   = ADDR_W'(OFS_DATA);
    localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFS_CTRL);

    // Decode each register's command from address and strobe.
    always_comb begin
        cmd.status_rd = rd_en && (addr == A_STATUS);
        cmd.data_acc  = (rd_en || wr_en) && (addr == A_DATA);
        cmd.ctrl_wr   = wr_en && (addr == A_CTRL);
        cmd.ctrl_rd   = rd_en && (addr == A_CTRL);
    end
endmodule

// File: rtl/brkf_ctrl.sv
// Break control: holds the clear-enable bit and gates the second step.
// Assumes brk_active is synchronous to clk.
module brkf_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr,
    input  logic wr_bit,
    input  logic data_acc,
    input  logic brk_active,
    output logic clr_en,
    output logic clr_go
);
    // Store the clear-enable bit; reset value protects flags.
    always_ff @(posedge clk) begin
        if (!rst_n)
            clr_en <= 1'b0;
        else if (ctrl_wr)
            clr_en <= wr_bit;
    end

    // Permit the second step unless break freezes clearing.
    always_comb begin
        clr_go = data_acc && (!brk_active || clr_en);
    end
endmodule

// File: rtl/brkf_flag_cell.sv
// One status flag with its armed marker for the two-step clear.
// Assumes arm_load and clr_go never come from the same access.
module brkf_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic arm_load,
    input  logic clr_go,
    output logic flag_q,
    output logic arm_q
);
    logic flag_n;
    logic arm_n;

    // Next flag: a set event wins over an armed clear.
    always_comb begin
        flag_n = set_evt || (flag_q && !(clr_go && arm_q));
    end

    // Next marker: set event or performed clear disarms, status read arms.
    always_comb begin
        if (set_evt || clr_go)
            arm_n = 1'b0;
        else if (arm_load)
            arm_n = flag_q;
        else
            arm_n = arm_q;
    end

    // Hold flag and marker; reset clears both.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
            arm_q  <= 1'b0;
        end else begin
            flag_q <= flag_n;
            arm_q  <= arm_n;
        end
    end
endmodule

// File: rtl/brkf_flag_bank.sv
// Top: bank of break-protected two-step status flags on a simple bus.
// Assumes NUM_FLAGS <= DATA_W and single-cycle accesses.
module brkf_flag_bank
    import brkf_pkg::*;
#(
    parameter int unsigned NUM_FLAGS = 4,
    parameter int unsigned ADDR_W    = 2,
    parameter int unsigned DATA_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rd_en,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wr_data,
    output logic [DATA_W-1:0]    rd_data,
    input  logic [NUM_FLAGS-1:0] set_evt,
    input  logic                 brk_active,
    output logic [NUM_FLAGS-1:0] flags
);
    bus_cmd_t              cmd;
    logic                  clr_en;
    logic                  clr_go;
    logic [NUM_FLAGS-1:0]  arm_vec;
    logic [DATA_W-1:0]     rd_mux;
    logic                  unused_wr_hi;

    assign unused_wr_hi = ^wr_data[DATA_W-1:1];

    brkf_regif #(.ADDR_W(ADDR_W)) u_regif (
        .rd_en (rd_en),
        .wr_en (wr_en),
        .addr  (addr),
        .cmd   (cmd)
    );

    brkf_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (cmd.ctrl_wr),
        .wr_bit     (wr_data[0]),
        .data_acc   (cmd.data_acc),
        .brk_active (brk_active),
        .clr_en     (clr_en),
        .clr_go     (clr_go)
    );

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_cell
        brkf_flag_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_evt  (set_evt[i]),
            .arm_load (cmd.status_rd),
            .clr_go   (clr_go),
            .flag_q   (flags[i]),
            .arm_q    (arm_vec[i])
        );
    end

    // Select read data for the addressed register; unmapped reads give zero.
    always_comb begin
        rd_mux = '0;
        if (cmd.status_rd)
            rd_mux[NUM_FLAGS-1:0] = flags;
        else if (cmd.ctrl_rd)
            rd_mux[0] = clr_en;
    end

    // Register read data on each read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else if (rd_en)
            rd_data <= rd_mux;
    end
endmodule

// File: rtl/brkf_checker.sv
// Checker: temporal properties of the flag bank, bound to the top module.
module brkf_checker
    import brkf_pkg::*;
#(
    parameter int unsigned NUM_FLAGS = 4,
    parameter int unsigned ADDR_W    = 2,
    parameter int unsigned DATA_W    = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 rd_en,
    input logic                 wr_en,
    input logic [ADDR_W-1:0]    addr,
    input logic [DATA_W-1:0]    rd_data,
    input logic [NUM_FLAGS-1:0] set_evt,
    input logic                 brk_active,
    input logic [NUM_FLAGS-1:0] flags,
    input logic                 clr_en
);
    logic data_touch;
    assign data_touch = (rd_en || wr_en) && (addr == ADDR_W'(OFS_DATA));

    AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (flags == '0 && !clr_en)); // R1

    AST_STATUS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_W'(OFS_STATUS)) |=> (rd_data == DATA_W'($past(flags)))); // R2

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_evt != '0) |=> ((flags & $past(set_evt)) == $past(set_evt))); // R7

    AST_NO_FALL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !data_touch |=> ((flags & $past(flags)) == $past(flags))); // R9

    AST_BREAK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_active && !clr_en) |=> ((flags & $past(flags)) == $past(flags))); // R5

    AST_CTRL_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_W'(OFS_CTRL)) |=> (rd_data == DATA_W'($past(clr_en)))); // R8
endmodule

bind brkf_flag_bank brkf_checker #(
    .NUM_FLAGS (NUM_FLAGS),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en      (rd_en),
    .wr_en      (wr_en),
    .addr       (addr),
    .rd_data    (rd_data),
    .set_evt    (set_evt),
    .brk_active (brk_active),
    .flags      (flags),
    .clr_en     (clr_en)
);

// File: tb/brkf_flag_bank_bench.sv
// Bench: sweeps all flag patterns through every break mode.
module brkf_flag_bank_bench;
    localparam int NF = 4;
    localparam int AW = 2;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rd_en = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic [NF-1:0] set_evt = '0;
    logic          brk_active = 1'b0;
    logic [NF-1:0] flags;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    logic [DW-1:0] got;

    always #2 clk = ~clk;

    brkf_flag_bank #(.NUM_FLAGS(NF), .ADDR_W(AW), .DATA_W(DW)) u_brkf_flag_bank (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .set_evt(set_evt),
        .brk_active(brk_active), .flags(flags)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // One access starting at a falling edge; ends at the next falling edge.
    task automatic bus(input bit r, input bit w, input int a, input int d,
                       input logic [NF-1:0] s);
        rd_en = r; wr_en = w; addr = AW'(a); wr_data = DW'(d); set_evt = s;
        @(negedge clk);
        got = rd_data;
        rd_en = 0; wr_en = 0; set_evt = '0;
    endtask

    task automatic data_step(input bit as_read);
        bus(as_read, !as_read, 1, 8'h5A, '0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 flags after reset", int'(flags), 0);
        bus(1, 0, 2, 0, '0);
        chk("R1 clear-enable after reset", int'(got), 0);
        // R1: no arm after reset, so a data access clears nothing.
        bus(0, 0, 0, 0, 4'b0011);
        data_step(1);
        chk("R1 no arm after reset", int'(flags), 3);
        // R9: status write has no effect; unarmed data access keeps flags.
        bus(0, 1, 0, 8'hFF, '0);
        chk("R9 status write ignored", int'(flags), 3);
        data_step(0);
        chk("R9 unarmed data access", int'(flags), 3);
        // R8: control register keeps only bit 0.
        bus(0, 1, 2, 8'hFF, '0);
        bus(1, 0, 2, 0, '0);
        chk("R8 ctrl readback", int'(got), 1);
        bus(0, 1, 2, 8'h00, '0);
        bus(1, 0, 2, 0, '0);
        chk("R8 ctrl cleared", int'(got), 0);
        // R7: set event colliding with the clearing access.
        bus(0, 0, 0, 0, 4'b1111);
        bus(1, 0, 0, 0, '0);
        bus(1, 0, 1, 0, 4'b0101);
        chk("R7 set wins collision", int'(flags), 5);
        data_step(0);
        chk("R7 collided flags disarmed", int'(flags), 5);

        for (int mode = 0; mode < 4; mode++) begin
            bus(0, 1, 2, (mode == 2) ? 1 : 0, '0);
            for (int m1 = 0; m1 < 16; m1++) begin
                for (int m2 = 0; m2 < 16; m2++) begin
                    bit rd_kind = m1[0] ^ m2[0];
                    brk_active = 1'b0;
                    bus(1, 0, 0, 0, '0);
                    data_step(0);
                    chk("R3 bank cleared", int'(flags), 0);
                    bus(0, 0, 0, 0, NF'(m1));
                    bus(1, 0, 0, 0, '0);
                    chk("R2 status read", int'(got), m1);
                    if (mode == 0) begin
                        bus(0, 0, 0, 0, NF'(m2));
                        data_step(rd_kind);
                        chk("R4 only armed flags clear", int'(flags), m2);
                    end else if (mode == 1 || mode == 3) begin
                        if (mode == 1) bus(0, 0, 0, 0, NF'(m2));
                        brk_active = 1'b1;
                        if (mode == 3) bus(0, 0, 0, 0, NF'(m2));
                        data_step(rd_kind);
                        chk("R5 break freezes clear", int'(flags), m1 | m2);
                        brk_active = 1'b0;
                        data_step(!rd_kind);
                        chk("R5 armed step survives break", int'(flags), m2);
                    end else begin
                        bus(0, 0, 0, 0, NF'(m2));
                        brk_active = 1'b1;
                        data_step(rd_kind);
                        chk("R6 clear in break", int'(flags), m2);
                        brk_active = 1'b0;
                        bus(0, 0, 0, 0, '0);
                        chk("R6 stays cleared after break", int'(flags), m2);
                    end
                end
            end
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule